// File: doc/BRIEF.md
# Resumable NMI Trap State Registers

This block holds the machine-level trap state for resumable non-maskable interrupts in a small 32-bit core. It has four registers: a scratch word for the handler, the program counter saved at entry, a cause word, and a status word. The status word carries the NMI interrupt-enable bit and the privilege level that was in effect when the trap was taken. Software reaches the registers through a CSR port. The port takes an address, an operation (read, write, set or clear) and write data. Read data comes back in the same cycle.

The core's trap logic pulses an entry strobe when an NMI is taken, along with the current PC, the cause code and the current privilege. The block captures all three. It clears the enable bit, and it marks the cause word as interrupt-originated. When the return instruction retires, the core uses the saved PC and the saved privilege, which the block drives out at all times. The return strobe sets the enable bit again. Instruction decode, vector selection and pipeline flushing are the core's job.

Top module: `rnmi_csr_unit`

## Requirements
- R1: The block responds only to addresses 0x740 (scratch), 0x741 (saved PC), 0x742 (cause) and 0x744 (status). `csr_hit_o` is 1 only when `csr_en_i` is high and one of these addresses is presented. When there is no hit, `csr_rdata_o` is 0 and no register changes.
- R2: `csr_op_i` encodes 2'b00 read (no write), 2'b01 write, 2'b10 set (OR with the write data) and 2'b11 clear (AND with the inverted write data). The result is applied to the addressed register at the next clock edge. The scratch register keeps all 32 bits.
- R3: Bit 0 of the saved-PC register always reads 0, and writes to it are ignored. This holds for the CSR read and for `mnret_pc_o`.
- R4: After an entry strobe, the saved-PC register holds the presented PC with bit 0 cleared. `mnret_pc_o` shows this value from the next cycle.
- R5: Bit 31 of the cause word is read-only. It is 0 after reset and becomes 1 on entry. Bits 30:0 are writable by software. On entry they take `nmi_cause_i`, limited to the implemented `CauseW` low bits.
- R6: In the status word, the previous privilege sits at bits 12:11 and the enable bit at bit 3. All other status bits read 0.
- R7: An entry strobe clears the enable bit (`nmie_o` low the next cycle) and stores the privilege presented at entry into bits 12:11. A CSR set or write of bit 3 makes the enable bit 1 again.
- R8: The privilege field holds only 2'b11 (machine) or 2'b00 (user). A value of 2'b01 or 2'b10 that reaches it by write, set, clear or entry is stored as 2'b11.
- R9: `mnret_priv_o` always equals the stored privilege field, and `mnret_pc_o` always equals the saved PC. A return strobe sets the enable bit at the next edge and leaves the privilege field unchanged.
- R10: Reset gives 0 in the scratch, saved-PC and cause registers, and a status word of 0x0000_1800 (machine privilege, enable bit 0).
- R11: In a cycle where a CSR write meets an entry strobe, the entry's values win in the saved-PC, cause and status registers, and a write to scratch still takes effect. A return strobe wins over a CSR write to the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_en_i | input | 1 | CSR access valid |
| csr_addr_i | input | AddrW | CSR address |
| csr_op_i | input | 2 | CSR operation: 00 read, 01 write, 10 set, 11 clear |
| csr_wdata_i | input | 32 | CSR write operand |
| csr_hit_o | output | 1 | Access targets a register of this block |
| csr_rdata_o | output | 32 | Read data of the addressed register, 0 when there is no hit |
| nmi_entry_i | input | 1 | NMI taken this cycle |
| nmi_pc_i | input | 32 | PC at the trap |
| nmi_cause_i | input | 31 | Cause code at the trap |
| nmi_priv_i | input | 2 | Privilege at the trap |
| mnret_i | input | 1 | Resumable NMI return retired |
| mnret_pc_o | output | 32 | PC to resume at |
| mnret_priv_o | output | 2 | Privilege to resume in |
| nmie_o | output | 1 | NMI interrupt enable |

## Verification
The assertions check these properties on every cycle:
- the saved PC's low bit stays 0;
- the resume privilege is always machine or user;
- unmapped accesses read 0;
- an entry leaves the presented PC saved and the enable bit cleared;
- a return sets the enable bit;
- the enable bit and privilege hold when no event or status write occurs;
- the cause interrupt flag reads 1 once any entry has happened.

The remaining behaviours are shown only by the bench's scenarios:
- the read-modify-write results for each operation;
- the legalization of every privilege value under each operation;
- the values read back from each register;
- the outcome when a software write and a hardware event land in the same cycle.

// File: rtl/rnmi_csr_pkg.sv
package rnmi_csr_pkg;

  localparam int unsigned DataW = 32;

  localparam logic [11:0] ADDR_SCRATCH = 12'h740;
  localparam logic [11:0] ADDR_EPC     = 12'h741;
  localparam logic [11:0] ADDR_CAUSE   = 12'h742;
  localparam logic [11:0] ADDR_STATUS  = 12'h744;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_M = 2'b11;

  localparam int unsigned PrivLsb = 11;
  localparam int unsigned EnBit   = 3;

  typedef enum logic [1:0] {
    CSR_OP_READ  = 2'b00,
    CSR_OP_WRITE = 2'b01,
    CSR_OP_SET   = 2'b10,
    CSR_OP_CLEAR = 2'b11
  } csr_op_e;

  typedef enum logic [1:0] {
    SEL_SCRATCH,
    SEL_EPC,
    SEL_CAUSE,
    SEL_STATUS
  } csr_sel_e;

  typedef struct packed {
    logic [1:0] mnpp;
    logic       nmie;
  } nm_status_t;

  localparam nm_status_t STATUS_RESET = '{mnpp: PRIV_M, nmie: 1'b0};

  function automatic logic [DataW-1:0] csr_rmw(csr_op_e op, logic [DataW-1:0] cur,
                                               logic [DataW-1:0] wd);
    logic [DataW-1:0] res;
    unique case (op)
      CSR_OP_WRITE: res = wd;
      CSR_OP_SET:   res = cur | wd;
      CSR_OP_CLEAR: res = cur & ~wd;
      default:      res = cur;
    endcase
    return res;
  endfunction

  // Only U and M are kept, everything else collapses to M
  function automatic logic [1:0] legal_priv(logic [1:0] p);
    return (p == PRIV_U) ? PRIV_U : PRIV_M;
  endfunction

  function automatic logic [DataW-1:0] status_word(nm_status_t s);
    logic [DataW-1:0] w;
    w = '0;
    w[PrivLsb+:2] = s.mnpp;
    w[EnBit]      = s.nmie;
    return w;
  endfunction

endpackage

// File: rtl/rnmi_csr_reg.sv
module rnmi_csr_reg #(
  parameter int unsigned     Width    = 32,
  parameter logic [Width-1:0] ResetVal = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [Width-1:0] d_i,
  output logic [Width-1:0] q_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= ResetVal;
    end else if (we_i) begin
      q_o <= d_i;
    end
  end

endmodule

// File: rtl/rnmi_csr_decode.sv
module rnmi_csr_decode
  import rnmi_csr_pkg::*;
#(
  parameter int unsigned AddrW = 12
) (
  input  logic             en_i,
  input  logic [AddrW-1:0] addr_i,
  input  logic [1:0]       op_i,
  output logic             hit_o,
  output logic             wr_o,
  output csr_sel_e         sel_o
);

  logic match;

  always_comb begin
    match = 1'b1;
    sel_o = SEL_SCRATCH;
    if (addr_i == AddrW'(ADDR_SCRATCH)) begin
      sel_o = SEL_SCRATCH;
    end else if (addr_i == AddrW'(ADDR_EPC)) begin
      sel_o = SEL_EPC;
    end else if (addr_i == AddrW'(ADDR_CAUSE)) begin
      sel_o = SEL_CAUSE;
    end else if (addr_i == AddrW'(ADDR_STATUS)) begin
      sel_o = SEL_STATUS;
    end else begin
      match = 1'b0;
    end
  end

  assign hit_o = en_i & match;
  assign wr_o  = hit_o & (op_i != CSR_OP_READ);

endmodule

// File: rtl/rnmi_csr_status.sv
module rnmi_csr_status
  import rnmi_csr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             entry_i,
  input  logic [1:0]       entry_priv_i,
  input  logic             mnret_i,
  input  logic             sw_we_i,
  input  logic [DataW-1:0] sw_data_i,
  output nm_status_t       status_o
);

  nm_status_t d;
  logic       we;
  logic       unused_sw_bits;

  // Priority: entry, then return, then software
  always_comb begin
    d = status_o;
    if (entry_i) begin
      d.mnpp = legal_priv(entry_priv_i);
      d.nmie = 1'b0;
    end else if (mnret_i) begin
      d.nmie = 1'b1;
    end else begin
      d.mnpp = legal_priv(sw_data_i[PrivLsb+:2]);
      d.nmie = sw_data_i[EnBit];
    end
  end

  assign we = entry_i | mnret_i | sw_we_i;

  assign unused_sw_bits = ^{sw_data_i[DataW-1:PrivLsb+2], sw_data_i[PrivLsb-1:EnBit+1],
                            sw_data_i[EnBit-1:0]};

  rnmi_csr_reg #(
    .Width   ($bits(nm_status_t)),
    .ResetVal(STATUS_RESET)
  ) i_status_q (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (we),
    .d_i   (d),
    .q_o   (status_o)
  );

endmodule

// File: rtl/rnmi_csr_unit.sv
module rnmi_csr_unit
  import rnmi_csr_pkg::*;
#(
  parameter int unsigned AddrW  = 12,
  parameter int unsigned CauseW = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csr_en_i,
  input  logic [AddrW-1:0] csr_addr_i,
  input  logic [1:0]       csr_op_i,
  input  logic [31:0]      csr_wdata_i,
  output logic             csr_hit_o,
  output logic [31:0]      csr_rdata_o,
  input  logic             nmi_entry_i,
  input  logic [31:0]      nmi_pc_i,
  input  logic [30:0]      nmi_cause_i,
  input  logic [1:0]       nmi_priv_i,
  input  logic             mnret_i,
  output logic [31:0]      mnret_pc_o,
  output logic [1:0]       mnret_priv_o,
  output logic             nmie_o
);

  localparam int unsigned CodeW = DataW - 1;

  csr_sel_e         sel;
  logic             sw_wr;
  logic [DataW-1:0] cur_val;
  logic [DataW-1:0] new_val;
  logic [DataW-1:0] scratch_q;
  logic [DataW-2:0] epc_q;
  logic             cause_flag_q;
  logic [CodeW-1:0] cause_code;
  nm_status_t       status_q;
  logic             unused_bits;

  rnmi_csr_decode #(
    .AddrW(AddrW)
  ) i_decode (
    .en_i  (csr_en_i),
    .addr_i(csr_addr_i),
    .op_i  (csr_op_i),
    .hit_o (csr_hit_o),
    .wr_o  (sw_wr),
    .sel_o (sel)
  );

  always_comb begin
    unique case (sel)
      SEL_SCRATCH: cur_val = scratch_q;
      SEL_EPC:     cur_val = {epc_q, 1'b0};
      SEL_CAUSE:   cur_val = {cause_flag_q, cause_code};
      default:     cur_val = status_word(status_q);
    endcase
  end

  assign csr_rdata_o = csr_hit_o ? cur_val : '0;
  assign new_val     = csr_rmw(csr_op_e'(csr_op_i), cur_val, csr_wdata_i);

  rnmi_csr_reg #(
    .Width(DataW)
  ) i_scratch_q (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (sw_wr && sel == SEL_SCRATCH),
    .d_i   (new_val),
    .q_o   (scratch_q)
  );

  // Bit 0 of the saved PC is not stored
  rnmi_csr_reg #(
    .Width(DataW - 1)
  ) i_epc_q (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (nmi_entry_i | (sw_wr && sel == SEL_EPC)),
    .d_i   (nmi_entry_i ? nmi_pc_i[DataW-1:1] : new_val[DataW-1:1]),
    .q_o   (epc_q)
  );

  rnmi_csr_reg #(
    .Width(1)
  ) i_cause_flag_q (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .we_i  (nmi_entry_i),
    .d_i   (1'b1),
    .q_o   (cause_flag_q)
  );

  if (CauseW > 0) begin : g_cause_code
    logic [CauseW-1:0] code_q;
    rnmi_csr_reg #(
      .Width(CauseW)
    ) i_code_q (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (nmi_entry_i | (sw_wr && sel == SEL_CAUSE)),
      .d_i   (nmi_entry_i ? nmi_cause_i[CauseW-1:0] : new_val[CauseW-1:0]),
      .q_o   (code_q)
    );
    assign cause_code = CodeW'(code_q);
  end else begin : g_no_cause_code
    assign cause_code = '0;
  end

  rnmi_csr_status i_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .entry_i     (nmi_entry_i),
    .entry_priv_i(nmi_priv_i),
    .mnret_i     (mnret_i),
    .sw_we_i     (sw_wr && sel == SEL_STATUS),
    .sw_data_i   (new_val),
    .status_o    (status_q)
  );

  assign mnret_pc_o   = {epc_q, 1'b0};
  assign mnret_priv_o = status_q.mnpp;
  assign nmie_o       = status_q.nmie;

  assign unused_bits = ^{nmi_pc_i[0], new_val, nmi_cause_i};

endmodule

// File: rtl/rnmi_csr_chk.sv
module rnmi_csr_chk #(
  parameter int unsigned AddrW = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             csr_en_i,
  input logic [AddrW-1:0] csr_addr_i,
  input logic [1:0]       csr_op_i,
  input logic             csr_hit_o,
  input logic [31:0]      csr_rdata_o,
  input logic             nmi_entry_i,
  input logic [31:0]      nmi_pc_i,
  input logic             mnret_i,
  input logic [31:0]      mnret_pc_o,
  input logic [1:0]       mnret_priv_o,
  input logic             nmie_o
);

  logic seen_entry_q;
  logic status_wr;
  logic cause_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_entry_q <= 1'b0;
    else if (nmi_entry_i) seen_entry_q <= 1'b1;
  end

  assign status_wr = csr_en_i && csr_addr_i == AddrW'(12'h744) && csr_op_i != 2'b00;
  assign cause_rd  = csr_hit_o && csr_addr_i == AddrW'(12'h742);

  AST_EPC_LSB_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mnret_pc_o[0] == 1'b0); // R3

  AST_NO_HIT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !csr_hit_o |-> csr_rdata_o == 32'h0); // R1

  AST_ENTRY_SAVES_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_entry_i |=> mnret_pc_o == {$past(nmi_pc_i[31:1]), 1'b0}); // R4

  AST_ENTRY_CLEARS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_entry_i |=> !nmie_o); // R7

  AST_PRIV_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mnret_priv_o == 2'b00 || mnret_priv_o == 2'b11); // R8

  AST_RET_SETS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mnret_i && !nmi_entry_i) |=> nmie_o); // R9

  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nmi_entry_i && !mnret_i && !status_wr) |=> $stable(nmie_o) && $stable(mnret_priv_o)); // R6

  AST_CAUSE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_entry_q && cause_rd) |-> csr_rdata_o[31]); // R5

endmodule

bind rnmi_csr_unit rnmi_csr_chk #(.AddrW(AddrW)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .csr_en_i    (csr_en_i),
  .csr_addr_i  (csr_addr_i),
  .csr_op_i    (csr_op_i),
  .csr_hit_o   (csr_hit_o),
  .csr_rdata_o (csr_rdata_o),
  .nmi_entry_i (nmi_entry_i),
  .nmi_pc_i    (nmi_pc_i),
  .mnret_i     (mnret_i),
  .mnret_pc_o  (mnret_pc_o),
  .mnret_priv_o(mnret_priv_o),
  .nmie_o      (nmie_o)
);

// File: tb/test_rnmi_csr_unit.sv
`timescale 1ns/1ps
module test_rnmi_csr_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_en = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [1:0]  csr_op = '0;
  logic [31:0] csr_wdata = '0;
  logic        csr_hit;
  logic [31:0] csr_rdata;
  logic        entry = 1'b0;
  logic [31:0] entry_pc = '0;
  logic [30:0] entry_cause = '0;
  logic [1:0]  entry_priv = '0;
  logic        mnret = 1'b0;
  logic [31:0] ret_pc;
  logic [1:0]  ret_priv;
  logic        nmie;

  int n_tests = 0;
  int n_fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rnmi_csr_unit i_rnmi_csr_unit (
    .clk_i(clk), .rst_ni(rst_n),
    .csr_en_i(csr_en), .csr_addr_i(csr_addr), .csr_op_i(csr_op), .csr_wdata_i(csr_wdata),
    .csr_hit_o(csr_hit), .csr_rdata_o(csr_rdata),
    .nmi_entry_i(entry), .nmi_pc_i(entry_pc), .nmi_cause_i(entry_cause), .nmi_priv_i(entry_priv),
    .mnret_i(mnret), .mnret_pc_o(ret_pc), .mnret_priv_o(ret_priv), .nmie_o(nmie)
  );

  function automatic logic [31:0] exp_rmw(logic [1:0] op, logic [31:0] cur, logic [31:0] wd);
    case (op)
      2'b01:   return wd;
      2'b10:   return cur | wd;
      2'b11:   return cur & ~wd;
      default: return cur;
    endcase
  endfunction

  function automatic logic [1:0] exp_priv(logic [1:0] p);
    return (p == 2'b00) ? 2'b00 : 2'b11;
  endfunction

  function automatic logic [31:0] exp_status(logic [1:0] pp, logic en);
    return (32'(pp) << 11) | (32'(en) << 3);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one clocked cycle of stimulus; outputs are stable 1 ns after the following negedge
  task automatic step(logic en, logic [1:0] op, logic [11:0] addr, logic [31:0] wd,
                      logic ent, logic [31:0] pc, logic [30:0] cause, logic [1:0] priv,
                      logic ret);
    @(negedge clk);
    csr_en = en; csr_op = op; csr_addr = addr; csr_wdata = wd;
    entry = ent; entry_pc = pc; entry_cause = cause; entry_priv = priv; mnret = ret;
    @(negedge clk);
    csr_en = 1'b0; entry = 1'b0; mnret = 1'b0;
    #1;
  endtask

  task automatic csr(logic [1:0] op, logic [11:0] addr, logic [31:0] wd);
    step(1'b1, op, addr, wd, 1'b0, '0, '0, '0, 1'b0);
  endtask

  task automatic rd(logic [11:0] addr, output logic [31:0] data, output logic hit);
    @(negedge clk);
    csr_en = 1'b1; csr_op = 2'b00; csr_addr = addr; csr_wdata = 32'hFFFF_FFFF;
    #1;
    data = csr_rdata; hit = csr_hit;
    csr_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fails++;
      n_tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        h;
    logic [31:0] m_scr, m_epc, m_cause, raw, pre;
    logic [1:0]  m_pp;
    logic        m_en;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;

    // R10 reset state
    rd(12'h740, d, h); chk("R10 scratch", d, 32'h0);
    rd(12'h741, d, h); chk("R10 epc", d, 32'h0);
    rd(12'h742, d, h); chk("R10 cause", d, 32'h0);
    rd(12'h744, d, h); chk("R10 status", d, 32'h0000_1800);
    chk("R10 nmie", 32'(nmie), 32'h0);
    chk("R10 priv", 32'(ret_priv), 32'h3);
    m_scr = 0; m_epc = 0; m_cause = 0; m_pp = 2'b11; m_en = 1'b0;

    // R1 address sweep, preload scratch to see that misses read zero
    csr(2'b01, 12'h740, 32'hDEAD_BEEF); m_scr = 32'hDEAD_BEEF;
    for (int a = 12'h73C; a <= 12'h748; a++) begin
      logic exp_h;
      exp_h = (a == 12'h740) || (a == 12'h741) || (a == 12'h742) || (a == 12'h744);
      rd(12'(a), d, h);
      chk("R1 hit", 32'(h), 32'(exp_h));
      if (!exp_h) chk("R1 miss data", d, 32'h0);
    end
    csr(2'b01, 12'h743, 32'h1234_5678);
    csr(2'b01, 12'h745, 32'h1234_5678);
    step(1'b0, 2'b01, 12'h740, 32'h0, 1'b0, '0, '0, '0, 1'b0);
    rd(12'h740, d, h); chk("R1 scratch untouched", d, m_scr);
    @(negedge clk); csr_en = 1'b0; csr_addr = 12'h740; #1;
    chk("R1 no enable no hit", 32'(csr_hit), 32'h0);

    // R2 scratch operations
    begin
      logic [1:0]  ops [4] = '{2'b01, 2'b10, 2'b11, 2'b00};
      logic [31:0] wds [4] = '{32'hA5A5_5A5A, 32'h0F00_00F0, 32'hA000_000A, 32'hFFFF_FFFF};
      for (int i = 0; i < 4; i++) begin
        csr(ops[i], 12'h740, wds[i]);
        m_scr = exp_rmw(ops[i], m_scr, wds[i]);
        rd(12'h740, d, h); chk("R2 scratch op", d, m_scr);
      end
    end

    // R3 saved PC low bit
    csr(2'b01, 12'h741, 32'hFFFF_FFFF); m_epc = 32'hFFFF_FFFE;
    rd(12'h741, d, h); chk("R3 epc read", d, m_epc);
    chk("R3 ret pc", ret_pc, m_epc);
    csr(2'b11, 12'h741, 32'h0F0F_0F0F); m_epc = m_epc & ~32'h0F0F_0F0F;
    rd(12'h741, d, h); chk("R3 epc clear", d, m_epc);

    // R5 cause software access before any entry
    csr(2'b01, 12'h742, 32'hFFFF_FFFF); m_cause = 32'h7FFF_FFFF;
    rd(12'h742, d, h); chk("R5 cause flag read-only", d, m_cause);
    csr(2'b11, 12'h742, 32'h0000_FFFF); m_cause = 32'h7FFF_0000;
    rd(12'h742, d, h); chk("R5 cause clear", d, m_cause);

    // R6 R8 status field layout and privilege legalization sweep
    for (int op = 1; op <= 3; op++) begin
      for (int v = 0; v < 4; v++) begin
        logic [31:0] wd;
        pre = (op == 3) ? 32'hFFFF_FFFF : 32'h0;
        csr(2'b01, 12'h744, pre);
        m_pp = exp_priv(pre[12:11]); m_en = pre[3];
        wd = (32'(v) << 11) | ((op == 3) ? 32'h0 : 32'hFFFF_E7FF);
        csr(2'(op), 12'h744, wd);
        raw = exp_rmw(2'(op), exp_status(m_pp, m_en), wd);
        m_pp = exp_priv(raw[12:11]); m_en = raw[3];
        rd(12'h744, d, h); chk("R6 R8 status word", d, exp_status(m_pp, m_en));
        chk("R8 ret priv", 32'(ret_priv), 32'(m_pp));
        chk("R6 nmie", 32'(nmie), 32'(m_en));
      end
    end

    // R4 R5 R7 entry sweep over privilege
    for (int p = 0; p < 4; p++) begin
      logic [31:0] pc;
      logic [30:0] cs;
      csr(2'b10, 12'h744, 32'h8);
      chk("R7 software sets nmie", 32'(nmie), 32'h1);
      pc = 32'h8000_0000 + 32'(p) * 32'h111 + 32'(p & 1);
      cs = 31'(p * 3 + 5);
      step(1'b0, 2'b00, 12'h0, 32'h0, 1'b1, pc, cs, 2'(p), 1'b0);
      m_epc = pc & ~32'h1; m_cause = {1'b1, cs}; m_pp = exp_priv(2'(p)); m_en = 1'b0;
      chk("R4 ret pc after entry", ret_pc, m_epc);
      chk("R7 nmie cleared", 32'(nmie), 32'h0);
      chk("R7 R8 priv saved", 32'(ret_priv), 32'(m_pp));
      rd(12'h741, d, h); chk("R4 epc read", d, m_epc);
      rd(12'h742, d, h); chk("R5 cause after entry", d, m_cause);
    end
    csr(2'b01, 12'h742, 32'h0000_0000);
    rd(12'h742, d, h); chk("R5 flag stays set", d, 32'h8000_0000);

    // R9 return
    csr(2'b01, 12'h744, 32'h0); m_pp = 2'b00; m_en = 1'b0;
    chk("R9 ret priv", 32'(ret_priv), 32'h0);
    chk("R9 ret pc", ret_pc, m_epc);
    step(1'b0, 2'b00, 12'h0, 32'h0, 1'b0, '0, '0, '0, 1'b1);
    chk("R9 nmie set", 32'(nmie), 32'h1);
    chk("R9 priv kept", 32'(ret_priv), 32'h0);
    rd(12'h744, d, h); chk("R9 status word", d, 32'h0000_0008);

    // R11 collisions
    step(1'b1, 2'b01, 12'h741, 32'h5555_5554, 1'b1, 32'h1000_0003, 31'h7, 2'b00, 1'b0);
    rd(12'h741, d, h); chk("R11 entry over epc write", d, 32'h1000_0002);
    step(1'b1, 2'b01, 12'h744, 32'h0000_1808, 1'b1, 32'h2000_0000, 31'h9, 2'b00, 1'b0);
    rd(12'h744, d, h); chk("R11 entry over status write", d, 32'h0);
    step(1'b1, 2'b11, 12'h744, 32'h0000_0008, 1'b0, '0, '0, '0, 1'b1);
    chk("R11 return over status clear", 32'(nmie), 32'h1);
    step(1'b1, 2'b01, 12'h742, 32'h0000_0000, 1'b1, 32'h3000_0000, 31'h4AB, 2'b11, 1'b0);
    rd(12'h742, d, h); chk("R11 entry over cause write", d, 32'h8000_04AB);
    step(1'b1, 2'b01, 12'h740, 32'hCAFE_F00D, 1'b1, 32'h4000_0000, 31'h1, 2'b11, 1'b0);
    rd(12'h740, d, h); chk("R11 scratch write with entry", d, 32'hCAFE_F00D);
    chk("R11 priv from entry", 32'(ret_priv), 32'h3);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fails);
    $finish;
  end

endmodule